// File: doc/BRIEF.md
# Self-Synchronizing PRBS Bit Error Checker

This block checks a serial bit stream that should carry a maximal-length pseudo-random sequence. It gets one bit per valid strobe and has no separate framing or sync input. An internal reference register of `PRBS_LEN` bits uses the transmitter's feedback taps. It starts by shifting in the received bits, which is open-loop acquisition. After a long enough run of bits that match its prediction, it switches its input multiplexer over to its own predicted bit. From then on it runs as a free local copy of the sequence, and every received bit is compared against it.

While in lock, each mismatch produces a one-cycle error pulse. Two saturating counters track the errors found and the bits checked. The checker never decides by itself that lock is lost. Software watches the counters and pulses the relock input, which sends the checker back to acquisition.

A second copy of the tracking core watches the error stream. When the stream slips by a bit, the error stream becomes a shifted copy of the same sequence. The second core then locks onto it and raises the slip flag.

Top module: `prbs_lock_checker`

## Requirements
- R1: With the default taps (feedback polynomial 1 + x^6 + x^7), the predicted bit is the XOR of the bits received 6 and 7 positions earlier. While locked, a valid bit that differs from this prediction raises `bit_err` for exactly the one cycle after the clock edge that accepts the bit.
- R2: Before lock, the reference shifts in the received bits. After lock, it shifts in its own prediction. A single wrong bit while locked therefore adds exactly 1 to `err_count`.
- R3: `in_lock` rises on the clock edge that accepts the valid bit completing a run of `PRBS_LEN + EXTRA_RUN` consecutive matching bits (39 by default). Any mismatch before that point restarts the run from zero.
- R4: Once set, `in_lock` stays high whatever errors follow, until `relock_req`.
- R5: Mismatches seen before lock are never counted. While locked, `err_count` counts mismatching valid bits and `chk_count` counts all valid bits.
- R6: A reference register holding all zeros predicts a one. An all-zeros input stream therefore never reaches lock.
- R7: The second core receives the mismatch flag of each valid bit accepted while locked. `slip_det` rises once that core has seen a run of 39 matching error bits, which happens after the stream gains or loses a bit.
- R8: `relock_req` clears `in_lock`, `slip_det`, `bit_err`, both counters and both run counters on the next edge. A bit presented in the same cycle is ignored.
- R9: Both counters stop at 2^`CNT_W`-1 and never wrap.
- R10: After reset all outputs are zero.
- R11: A cycle without `sample_vld` changes neither the reference, the lock state nor the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | Strobe: `sample_bit` holds a new received bit |
| sample_bit | input | 1 | Received serial data bit |
| relock_req | input | 1 | Return to open-loop acquisition and clear the counters |
| in_lock | output | 1 | Reference has locked and runs closed loop |
| bit_err | output | 1 | One-cycle pulse for each mismatching bit while locked |
| slip_det | output | 1 | Error stream recognised as the sequence: a slip has occurred |
| err_count | output | CNT_W | Saturating count of errors while locked |
| chk_count | output | CNT_W | Saturating count of bits checked while locked |

## Verification
The hardest state to reach is the slip flag. It needs the checker to be locked first. Then one bit must vanish from an otherwise perfect stream, and the second core must see a run of 39 matching bits in an error stream that the bench never drives directly. The bench reaches this by skipping one output of its own generator after lock and then sending clean sequence bits. Counter saturation is reached by instantiating 8-bit counters and sending a long inverted burst while the checker is locked. The same burst also shows that lock survives a total loss of the stream.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  typedef enum logic {
    PH_ACQUIRE = 1'b0,
    PH_TRACK   = 1'b1
  } phase_e;

  function automatic int lock_len(input int reg_len, input int extra);
    return reg_len + extra;
  endfunction

endpackage

// File: rtl/prbs_sat_count.sv
module prbs_sat_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != TOP)) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ((cnt == TOP) && !clr) |=> (cnt == TOP)); // R9

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!clr && (cnt != TOP)) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1))); // R5

endmodule

// File: rtl/prbs_track_core.sv
module prbs_track_core
  import prbs_chk_pkg::*;
#(
  parameter int              N         = 7,
  parameter logic [N-1:0]    TAPS      = 7'b1100000,
  parameter int              EXTRA_RUN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic vld,
  input  logic din,
  output logic mism,
  output logic synced
);

  localparam int LOCK_RUN = lock_len(N, EXTRA_RUN);
  localparam int RUN_W    = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);

  logic [N-1:0]     sr;
  logic [RUN_W-1:0] run;
  phase_e           phase;
  logic             pred;
  logic             feed;

  // Prediction: tap parity, forced to one when the register is empty.
  always_comb begin
    pred = (^(sr & TAPS)) | ~(|sr);
    mism = vld & (din != pred);
    feed = (phase == PH_TRACK) ? pred : din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      run   <= '0;
      phase <= PH_ACQUIRE;
    end else if (clr) begin
      run   <= '0;
      phase <= PH_ACQUIRE;
    end else if (vld) begin
      sr <= {sr[N-2:0], feed};
      if (phase == PH_ACQUIRE) begin
        if (mism) begin
          run <= '0;
        end else if (run == RUN_LAST) begin
          phase <= PH_TRACK;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  end

  assign synced = (phase == PH_TRACK);

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (synced && !clr) |=> synced); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!vld && !clr) |=> ($stable(synced) && $stable(sr))); // R11

  AST_EMPTY_WANTS_ONE: assert property (@(posedge clk) disable iff (rst)
    (vld && (sr == '0) && !din) |-> mism); // R6

  AST_CLR_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    clr |=> !synced); // R8

endmodule

// File: rtl/prbs_lock_checker.sv
module prbs_lock_checker #(
  parameter int                  PRBS_LEN  = 7,
  parameter logic [PRBS_LEN-1:0] TAP_MASK  = 7'b1100000,
  parameter int                  EXTRA_RUN = 32,
  parameter int                  CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_vld,
  input  logic             sample_bit,
  input  logic             relock_req,
  output logic             in_lock,
  output logic             bit_err,
  output logic             slip_det,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] chk_count
);

  logic main_mism;
  logic slip_mism;
  logic slip_vld;
  logic cnt_bit;
  logic cnt_err;

  prbs_track_core #(
    .N         (PRBS_LEN),
    .TAPS      (TAP_MASK),
    .EXTRA_RUN (EXTRA_RUN)
  ) u_main (
    .clk    (clk),
    .rst    (rst),
    .clr    (relock_req),
    .vld    (sample_vld),
    .din    (sample_bit),
    .mism   (main_mism),
    .synced (in_lock)
  );

  // Slip watcher: error flags of checked bits form its input stream.
  assign slip_vld = sample_vld & in_lock & ~relock_req;

  prbs_track_core #(
    .N         (PRBS_LEN),
    .TAPS      (TAP_MASK),
    .EXTRA_RUN (EXTRA_RUN)
  ) u_slip (
    .clk    (clk),
    .rst    (rst),
    .clr    (relock_req),
    .vld    (slip_vld),
    .din    (main_mism),
    .mism   (slip_mism),
    .synced (slip_det)
  );

  assign cnt_bit = sample_vld & in_lock;
  assign cnt_err = main_mism & in_lock;

  always_ff @(posedge clk) begin
    if (rst || relock_req) begin
      bit_err <= 1'b0;
    end else begin
      bit_err <= cnt_err;
    end
  end

  prbs_sat_count #(.W(CNT_W)) u_err_cnt (
    .clk (clk),
    .rst (rst),
    .clr (relock_req),
    .inc (cnt_err),
    .cnt (err_count)
  );

  prbs_sat_count #(.W(CNT_W)) u_bit_cnt (
    .clk (clk),
    .rst (rst),
    .clr (relock_req),
    .inc (cnt_bit),
    .cnt (chk_count)
  );

  AST_PULSE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    bit_err |-> $past(in_lock)); // R5

  AST_ERRS_WITHIN_BITS: assert property (@(posedge clk) disable iff (rst)
    err_count <= chk_count); // R5

  AST_RELOCK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    relock_req |=> (!in_lock && !slip_det && !bit_err && (err_count == '0) && (chk_count == '0))); // R8

  AST_SLIP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !slip_vld |-> !slip_mism); // R7

endmodule

// File: tb/tb_prbs_lock_checker.sv
`timescale 1ns/1ps
module tb_prbs_lock_checker;

  localparam int PN    = 7;
  localparam int LOCKN = 39;
  localparam int CW    = 8;
  localparam int MAXC  = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_vld = 1'b0;
  logic sample_bit = 1'b0;
  logic relock_req = 1'b0;
  logic in_lock, bit_err, slip_det;
  logic [CW-1:0] err_count, chk_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prbs_lock_checker #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .sample_vld(sample_vld), .sample_bit(sample_bit),
    .relock_req(relock_req), .in_lock(in_lock), .bit_err(bit_err),
    .slip_det(slip_det), .err_count(err_count), .chk_count(chk_count)
  );

  // Reference model state: history of loaded bits, newest at index 0.
  int hist [2][PN];
  int run [2];
  bit lk [2];
  int m_err, m_bits;
  bit m_ep;
  int txh [PN];

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pred_of(int c);
    int z = 0;
    for (int k = 0; k < PN; k++) z |= hist[c][k];
    if (z == 0) return 1'b1;
    return bit'(hist[c][5] ^ hist[c][6]);
  endfunction

  task automatic core_step(int c, bit v, bit d, bit mm);
    bit ld;
    if (!v) return;
    ld = lk[c] ? pred_of(c) : d;
    for (int k = PN - 1; k > 0; k--) hist[c][k] = hist[c][k-1];
    hist[c][0] = ld;
    if (!lk[c]) begin
      if (mm) run[c] = 0;
      else begin
        run[c]++;
        if (run[c] == LOCKN) lk[c] = 1'b1;
      end
    end
  endtask

  task automatic model_update(bit v, bit d, bit rs);
    bit mm0, mm1, was;
    if (rs) begin
      lk[0] = 0; lk[1] = 0; run[0] = 0; run[1] = 0;
      m_err = 0; m_bits = 0; m_ep = 0;
      return;
    end
    mm0 = v && (d != pred_of(0));
    was = lk[0];
    m_ep = was && mm0;
    if (was && v) begin
      if (m_bits < MAXC) m_bits++;
      if (mm0 && m_err < MAXC) m_err++;
    end
    mm1 = (v && was) && (mm0 != pred_of(1));
    core_step(1, v && was, mm0, mm1);
    core_step(0, v, d, mm0);
  endtask

  task automatic compare_all();
    chk("R3 in_lock", in_lock, lk[0]);
    chk("R1 bit_err", bit_err, m_ep);
    chk("R5 err_count", err_count, m_err);
    chk("R5 chk_count", chk_count, m_bits);
    chk("R7 slip_det", slip_det, lk[1]);
  endtask

  task automatic send(bit v, bit d, bit rs);
    @(negedge clk);
    compare_all();
    sample_vld = v; sample_bit = d; relock_req = rs;
    model_update(v, d, rs);
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  function automatic bit tx_next();
    bit b = bit'(txh[5] ^ txh[6]);
    for (int k = PN - 1; k > 0; k--) txh[k] = txh[k-1];
    txh[0] = b;
    return b;
  endfunction

  task automatic send_prbs(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 4 == 3)) send(1'b0, 1'b0, 1'b0);
      send(1'b1, tx_next(), 1'b0);
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e0;
    int b0;
    bit b;
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < PN; k++) hist[c][k] = 0;
      run[c] = 0; lk[c] = 0;
    end
    for (int k = 0; k < PN; k++) txh[k] = (k == 0) ? 1 : 0;
    m_err = 0; m_bits = 0; m_ep = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    after_edge();
    // R10: reset state
    chk("R10 in_lock", in_lock, 0);
    chk("R10 bit_err", bit_err, 0);
    chk("R10 slip_det", slip_det, 0);
    chk("R10 err_count", err_count, 0);
    chk("R10 chk_count", chk_count, 0);

    // R6: all-zeros input never locks
    for (int i = 0; i < 100; i++) send(1'b1, 1'b0, 1'b0);
    after_edge();
    chk("R6 zeros no lock", in_lock, 0);

    // R3: error during acquisition restarts the run
    send_prbs(20, 1'b0);
    send(1'b1, ~tx_next(), 1'b0);
    send_prbs(30, 1'b0);
    after_edge();
    chk("R3 not yet locked", in_lock, 0);
    send_prbs(40, 1'b1);
    after_edge();
    chk("R3 locked", in_lock, 1);
    chk("R5 pre-lock errors uncounted", err_count, 0);

    // R11: idle cycles change nothing
    b0 = chk_count;
    for (int i = 0; i < 5; i++) send(1'b0, 1'b1, 1'b0);
    after_edge();
    chk("R11 idle chk_count", chk_count, b0);
    chk("R11 idle in_lock", in_lock, 1);

    // R1/R2: a single error in lock
    e0 = err_count;
    send(1'b1, ~tx_next(), 1'b0);
    after_edge();
    chk("R1 bit_err pulse", bit_err, 1);
    send(1'b1, tx_next(), 1'b0);
    after_edge();
    chk("R1 bit_err single cycle", bit_err, 0);
    send_prbs(20, 1'b0);
    after_edge();
    chk("R2 one error counted once", err_count, e0 + 1);

    // R4/R9: long inverted burst keeps lock and saturates counters
    for (int i = 0; i < 300; i++) send(1'b1, ~tx_next(), 1'b0);
    after_edge();
    chk("R4 lock held", in_lock, 1);
    chk("R9 err_count saturates", err_count, MAXC);
    chk("R9 chk_count saturates", chk_count, MAXC);

    // R8: relock clears, bit in the same cycle ignored
    b = tx_next();
    send(1'b1, ~b, 1'b1);
    after_edge();
    chk("R8 in_lock cleared", in_lock, 0);
    chk("R8 err_count cleared", err_count, 0);
    chk("R8 chk_count cleared", chk_count, 0);
    chk("R8 bit_err cleared", bit_err, 0);
    send_prbs(60, 1'b0);
    after_edge();
    chk("R3 relocked", in_lock, 1);
    chk("R7 no slip on clean stream", slip_det, 0);

    // R7: drop one bit from the stream
    void'(tx_next());
    send_prbs(90, 1'b0);
    after_edge();
    chk("R7 slip detected", slip_det, 1);
    chk("R4 lock kept through slip", in_lock, 1);

    send(1'b0, 1'b0, 1'b1);
    after_edge();
    chk("R8 slip cleared", slip_det, 0);
    send(1'b0, 1'b0, 1'b0);
    send(1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule